// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an external 2048 x 8 asynchronous static RAM. The host gives a single-cycle request: a valid flag, a write flag, an 11-bit address and a write byte. The block turns it into a timed sequence of active-low chip select, write enable and output enable. Every strobe duration is a parameter counted in clock cycles. The shared 8-bit data bus is modelled as three signals: an output byte, an input byte and a drive-enable.

Writes are controlled by write enable. Output enable stays low through the write pulse, so the pulse is stretched to the larger of the plain pulse width and (memory output turn-off time + data overlap time). The controller starts driving the bus only after the memory's turn-off time has elapsed within the pulse. It stops driving at the hold time after the pulse ends. Reads hold chip select and output enable low for the access count, capture the byte and raise a one-cycle valid pulse. Between requests chip select is held high, which keeps the memory in its standby state.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During and immediately after reset: `ready`=1, `memCsN`=`memWeN`=`memOeN`=1, `memDrive`=0, `rdValid`=0.
- R2: Whenever the block is idle (`ready`=1), `memCsN` is 1 and `memDrive` is 0.
- R3: A read accepted at a clock edge holds `memCsN`=0, `memOeN`=0, `memWeN`=1 for ACCESS_CYC cycles. `rdValid` is then high for exactly one cycle, ACCESS_CYC edges after the accept edge, with `rdData` equal to the addressed byte. `memCsN` is already back at 1 in that cycle.
- R4: Each write asserts `memWeN`=0 for exactly max(PULSE_CYC, WHZ_CYC+DW_CYC) cycles (4 by default), with `memOeN`=0 and `memCsN`=0 throughout the pulse.
- R5: `memDrive` rises WHZ_CYC cycles into the write pulse and ends HOLD_CYC cycles after the pulse ends. It is never 1 while `memOeN`=0 and `memWeN`=1.
- R6: `memAddr` does not change while `memCsN` and `memWeN` are both 0.
- R7: `ready` is 0 from the accept edge until the sequence ends. A request presented while `ready`=0 starts no sequence and writes nothing.
- R8: A write keeps `ready` low for SETUP_CYC + pulse + HOLD_CYC + RECOV_CYC cycles (4 by default).
- R9: A byte written to an address is read back from it, including addresses 0 and 2047, and a later write overwrites it.
- R10: A behavioural memory attached to the pins sees no bus contention, no short write pulse and no write data valid for fewer than DW_CYC cycles before the pulse ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request strobe, taken when ready is high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Host address |
| reqWdata | input | DATA_W | Host write byte |
| ready | output | 1 | High when a request can be accepted |
| rdValid | output | 1 | One-cycle pulse marking rdData valid |
| rdData | output | DATA_W | Captured read byte |
| memCsN | output | 1 | Memory chip select, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memAddr | output | ADDR_W | Memory address bus |
| memDout | output | DATA_W | Byte driven onto the memory data bus |
| memDin | input | DATA_W | Byte read from the memory data bus |
| memDrive | output | 1 | Drive-enable for memDout onto the data bus |

## Verification
A read's `rdValid` pulse is due ACCESS_CYC edges after the accept edge, and it must be gone one cycle later. A default write ends with `ready` back high four edges after acceptance, and `memDrive` first appears WHZ_CYC cycles into the low pulse. The bench drives and samples on falling edges and counts falling edges from the accept edge to each event. It compares those counts with the values above, so a result one cycle early or late is reported. A behavioural memory counts cycles on the pins at rising edges and judges write pulse length, data overlap, contention and address stability.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_WRECOV
  } ctrl_state_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic csN;
    logic weN;
    logic oeN;
    logic drive;
    logic load;
    logic capture;
  } strobe_t;

endpackage

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ACCESS_CYC = 3,
  parameter int SETUP_CYC  = 0,
  parameter int PULSE_CYC  = 3,
  parameter int WHZ_CYC    = 2,
  parameter int DW_CYC     = 2,
  parameter int HOLD_CYC   = 0,
  parameter int RECOV_CYC  = 0
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    ready,
  output strobe_t strb
);

  localparam int ACC_LEN   = (ACCESS_CYC < 1) ? 1 : ACCESS_CYC;
  localparam int PULSE_EFF = (PULSE_CYC > WHZ_CYC + DW_CYC) ? PULSE_CYC : WHZ_CYC + DW_CYC;
  localparam int MAX_A     = (ACC_LEN > PULSE_EFF) ? ACC_LEN : PULSE_EFF;
  localparam int MAX_B     = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int MAX_C     = (MAX_B > RECOV_CYC) ? MAX_B : RECOV_CYC;
  localparam int MAX_LEN   = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int CNT_W     = $clog2(MAX_LEN + 1);

  ctrl_state_e      state, nState;
  logic [CNT_W-1:0] cnt, nCnt;
  logic             accept, capture;
  logic             csQ, weQ, oeQ, drvQ;

  // {csN, weN, oeN, drive} for a given state and in-state cycle count
  function automatic logic [3:0] pinsFor(ctrl_state_e s, logic [CNT_W-1:0] c);
    case (s)
      ST_READ:   return 4'b0100;
      ST_WSETUP: return 4'b0100;
      ST_WPULSE: return {3'b000, (int'(c) >= WHZ_CYC)};
      ST_WHOLD:  return 4'b0111;
      ST_WRECOV: return 4'b0110;
      default:   return 4'b1110;
    endcase
  endfunction

  always_comb begin
    nState  = state;
    nCnt    = cnt + 1'b1;
    accept  = 1'b0;
    capture = 1'b0;
    case (state)
      ST_IDLE: begin
        nCnt = '0;
        if (reqValid) begin
          accept = 1'b1;
          if (!reqWrite)          nState = ST_READ;
          else if (SETUP_CYC > 0) nState = ST_WSETUP;
          else                    nState = ST_WPULSE;
        end
      end
      ST_READ:
        if (cnt == CNT_W'(ACC_LEN - 1)) begin
          capture = 1'b1;
          nState  = ST_IDLE;
          nCnt    = '0;
        end
      ST_WSETUP:
        if (cnt == CNT_W'(SETUP_CYC - 1)) begin
          nState = ST_WPULSE;
          nCnt   = '0;
        end
      ST_WPULSE:
        if (cnt == CNT_W'(PULSE_EFF - 1)) begin
          nCnt = '0;
          if (HOLD_CYC > 0)       nState = ST_WHOLD;
          else if (RECOV_CYC > 0) nState = ST_WRECOV;
          else                    nState = ST_IDLE;
        end
      ST_WHOLD:
        if (cnt == CNT_W'(HOLD_CYC - 1)) begin
          nCnt   = '0;
          nState = (RECOV_CYC > 0) ? ST_WRECOV : ST_IDLE;
        end
      ST_WRECOV:
        if (cnt == CNT_W'(RECOV_CYC - 1)) begin
          nCnt   = '0;
          nState = ST_IDLE;
        end
      default: begin
        nState = ST_IDLE;
        nCnt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state                <= ST_IDLE;
      cnt                  <= '0;
      {csQ, weQ, oeQ, drvQ} <= 4'b1110;
    end else begin
      state                <= nState;
      cnt                  <= nCnt;
      {csQ, weQ, oeQ, drvQ} <= pinsFor(nState, nCnt);
    end
  end

  assign ready = (state == ST_IDLE);
  assign strb  = '{csN: csQ, weN: weQ, oeN: oeQ, drive: drvQ,
                   load: accept, capture: capture};

endmodule

// File: rtl/sram_ctrl_path.sv
`timescale 1ns/1ps
module sram_ctrl_path
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memDrive,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdDataQ;
  logic              rdValidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      rdDataQ  <= '0;
      rdValidQ <= 1'b0;
    end else begin
      // address only moves on accept, which happens with chip select high
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.capture) rdDataQ <= memDin;
      rdValidQ <= strb.capture;
    end
  end

  assign memAddr  = addrQ;
  assign memDout  = wdataQ;
  assign rdData   = rdDataQ;
  assign rdValid  = rdValidQ;
  assign memCsN   = strb.csN;
  assign memWeN   = strb.weN;
  assign memOeN   = strb.oeN;
  assign memDrive = strb.drive;

endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int ACCESS_CYC = 3,
  parameter int SETUP_CYC  = 0,
  parameter int PULSE_CYC  = 3,
  parameter int WHZ_CYC    = 2,
  parameter int DW_CYC     = 2,
  parameter int HOLD_CYC   = 0,
  parameter int RECOV_CYC  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              ready,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  input  logic [DATA_W-1:0] memDin,
  output logic              memDrive
);

  strobe_t strb;

  sram_ctrl_seq #(
    .ACCESS_CYC(ACCESS_CYC), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .WHZ_CYC(WHZ_CYC), .DW_CYC(DW_CYC), .HOLD_CYC(HOLD_CYC), .RECOV_CYC(RECOV_CYC)
  ) i_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .ready(ready), .strb(strb)
  );

  sram_ctrl_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_path (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memDin(memDin), .rdValid(rdValid), .rdData(rdData), .memCsN(memCsN),
    .memWeN(memWeN), .memOeN(memOeN), .memDrive(memDrive), .memAddr(memAddr),
    .memDout(memDout)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk #(
  parameter int ADDR_W    = 11,
  parameter int PULSE_CYC = 3,
  parameter int WHZ_CYC   = 2,
  parameter int DW_CYC    = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              ready,
  input logic              rdValid,
  input logic              memCsN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memDrive,
  input logic [ADDR_W-1:0] memAddr
);

  localparam int PULSE_EFF = (PULSE_CYC > WHZ_CYC + DW_CYC) ? PULSE_CYC : WHZ_CYC + DW_CYC;

  logic [15:0] lowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lowCnt <= '0;
    else if (!memWeN) lowCnt <= lowCnt + 16'd1;
    else              lowCnt <= '0;
  end

  // R2
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (memCsN && !memDrive));

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (lowCnt == 16'(PULSE_EFF)));

  // R4
  oe_low_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memOeN && !memCsN));

  // R5
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN && memWeN) |-> !memDrive);

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && !memWeN && $past(!memCsN && !memWeN)) |-> $stable(memAddr));

  // R7
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memCsN |-> !ready);

endmodule

bind sram_strobe_ctrl sram_ctrl_chk #(
  .ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC), .WHZ_CYC(WHZ_CYC), .DW_CYC(DW_CYC)
) i_chk (
  .clk(clk), .rstN(rstN), .ready(ready), .rdValid(rdValid), .memCsN(memCsN),
  .memWeN(memWeN), .memOeN(memOeN), .memDrive(memDrive), .memAddr(memAddr)
);

// File: tb/test_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module test_sram_strobe_ctrl;

  localparam int ACC  = 3;
  localparam int PUL  = 3;
  localparam int WHZ  = 2;
  localparam int DW   = 2;
  localparam int PEFF = (PUL > WHZ + DW) ? PUL : WHZ + DW;

  logic        clk = 0, rstN = 0;
  logic        reqValid = 0, reqWrite = 0;
  logic [10:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        ready, rdValid, memCsN, memWeN, memOeN, memDrive;
  logic [7:0]  rdData, memDout, memDin;
  logic [10:0] memAddr;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sram_strobe_ctrl #(.ACCESS_CYC(ACC), .PULSE_CYC(PUL), .WHZ_CYC(WHZ), .DW_CYC(DW))
  i_sram_strobe_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .ready(ready), .rdValid(rdValid),
    .rdData(rdData), .memCsN(memCsN), .memWeN(memWeN), .memOeN(memOeN),
    .memAddr(memAddr), .memDout(memDout), .memDin(memDin), .memDrive(memDrive)
  );

  // ---------------- behavioural memory ----------------
  logic [7:0]  mem [2048];
  int          weLow = 0, accCnt = 0, dvCnt = 0, violAddr = 0, violTim = 0;
  logic [10:0] prevAddr = '0;
  logic        prevWr = 0, prevRd = 0;
  logic        modelDrive;
  logic [7:0]  modelData;

  initial for (int i = 0; i < 2048; i++) mem[i] = 8'h00;

  assign modelDrive = !memCsN && !memOeN && (memWeN || weLow < WHZ);
  assign modelData  = (accCnt >= ACC - 1) ? mem[memAddr] : ~mem[memAddr];
  assign memDin     = modelDrive ? modelData : 8'h00;

  always @(posedge clk) begin
    if (rstN) begin
      logic wrAct, rdAct;
      wrAct = !memCsN && !memWeN;
      rdAct = !memCsN && !memOeN && memWeN;
      if (modelDrive && memDrive) violTim++;
      if (wrAct && prevWr && memAddr != prevAddr) violAddr++;
      if (wrAct) begin
        weLow++;
        if (memDrive) begin dvCnt++; mem[memAddr] = memDout; end
        else dvCnt = 0;
      end else begin
        if (prevWr && (weLow < PEFF || dvCnt < DW)) violTim++;
        weLow = 0;
        dvCnt = 0;
      end
      if (!rdAct) accCnt = 0;
      else if (prevRd && memAddr == prevAddr) accCnt++;
      else accCnt = 1;
      prevAddr = memAddr;
      prevWr   = wrAct;
      prevRd   = rdAct;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [10:0] a, input logic [7:0] d,
                         output int busy, output int weLowN, output int drvStart,
                         output bit oeOk);
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 0;
    busy = 0; weLowN = 0; drvStart = -1; oeOk = 1;
    while (!ready && busy < 50) begin
      busy++;
      if (!memWeN) begin
        if (memDrive && drvStart < 0) drvStart = weLowN;
        if (memOeN) oeOk = 0;
        weLowN++;
      end
      @(negedge clk);
    end
  endtask

  task automatic doRead(input logic [10:0] a, output int lat, output logic [7:0] d,
                        output bit csHigh, output bit oneCyc);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = a;
    @(negedge clk);
    reqValid = 0;
    lat = 0;
    while (!rdValid && lat < 50) begin lat++; @(negedge clk); end
    d = rdData;
    csHigh = memCsN;
    @(negedge clk);
    oneCyc = !rdValid;
  endtask

  // {write, address, data/expected}
  localparam logic [19:0] VEC [10] = '{
    {1'b1, 11'h000, 8'h3C}, {1'b1, 11'h7FF, 8'hC3}, {1'b1, 11'h155, 8'hA5},
    {1'b1, 11'h2AA, 8'h5A}, {1'b0, 11'h000, 8'h3C}, {1'b0, 11'h7FF, 8'hC3},
    {1'b0, 11'h155, 8'hA5}, {1'b0, 11'h2AA, 8'h5A}, {1'b1, 11'h155, 8'h0F},
    {1'b0, 11'h155, 8'h0F}
  };

  initial begin
    int busy, wl, ds, lat;
    bit oeOk, csHigh, oneCyc;
    logic [7:0] d;

    // R1 reset state
    @(negedge clk);
    chk(ready && memCsN && memWeN && memOeN && !memDrive && !rdValid, "R1 during reset",
        {ready, memCsN, memWeN, memOeN, memDrive, rdValid}, 6'b111100);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    chk(ready && memCsN && memWeN && memOeN && !memDrive && !rdValid, "R1 after reset",
        {ready, memCsN, memWeN, memOeN, memDrive, rdValid}, 6'b111100);

    // vector table
    foreach (VEC[i]) begin
      if (VEC[i][19]) begin
        doWrite(VEC[i][18:8], VEC[i][7:0], busy, wl, ds, oeOk);
        chk(wl == PEFF, "R4 pulse length", wl, PEFF);
        chk(oeOk, "R4 oe low in pulse", oeOk, 1);
        chk(ds == WHZ, "R5 drive start", ds, WHZ);
        chk(busy == PEFF, "R8 write busy", busy, PEFF);
      end else begin
        doRead(VEC[i][18:8], lat, d, csHigh, oneCyc);
        chk(lat == ACC, "R3 read latency", lat, ACC);
        chk(d == VEC[i][7:0], "R9 read data", d, VEC[i][7:0]);
        chk(csHigh, "R3 cs released", csHigh, 1);
        chk(oneCyc, "R3 one-cycle valid", oneCyc, 1);
      end
    end

    // R7 request while busy is ignored
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = 11'h100; reqWdata = 8'h11;
    @(negedge clk);
    chk(!ready, "R7 ready low", ready, 0);
    reqAddr = 11'h101; reqWdata = 8'h22;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    reqValid = 0;
    while (!ready) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk(memCsN && memWeN, "R7 no second sequence", memCsN, 1);
      @(negedge clk);
    end
    doRead(11'h101, lat, d, csHigh, oneCyc);
    chk(d == 8'h00, "R7 ignored write not stored", d, 0);
    doRead(11'h100, lat, d, csHigh, oneCyc);
    chk(d == 8'h11, "R9 accepted write stored", d, 8'h11);

    // R2 standby while idle
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(ready && memCsN && !memDrive, "R2 standby", {ready, memCsN, memDrive}, 3'b110);
    end

    chk(violAddr == 0, "R6 address stable in write", violAddr, 0);
    chk(violTim == 0, "R10 memory timing", violTim, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule